// File: doc/BRIEF.md
# Miss and Write Buffer Allocation Controller

This block manages the two bounded pools a non-blocking cache uses for outstanding work. One pool holds miss entries and the other holds write and writeback entries. Each allocation request carries a kind, an address and a size. The block chooses the pool, shapes the address and size, and stamps the entry with a rising order number. It returns the chosen slot on a one-cycle response, or it rejects the request when the pool has no free slot. When the request asks for it, the block also pulses a memory-side bus request whose cause is the pool index.

Blocking is kept as a three-bit cause mask. The CPU-side blocked output is high whenever any cause bit is set. A pool sets its cause bit when an allocation takes its last free slot. It clears that bit when a slot is freed from the full state. A third cause follows an external no-free-target indication. For each cause the block counts two things: how many blocking episodes it started, and the blocked cycles of each episode it ended last. An optional miss limit raises a sticky done flag after a set number of accepted miss-pool allocations.

Entries leave a pool in one of two ways. A write-pool entry is freed when it is marked in service. A miss-pool entry stays until it is released explicitly. A lookup port shows the stored contents of any slot.

Top module: `mac_alloc_ctrl`

## Requirements
- R1: Kind code 0 (cacheable miss) allocates in the miss pool (pool index 0) with address AND NOT(BLK_BYTES-1) and size BLK_BYTES.
- R2: Kind code 1 (write or writeback) allocates in the write pool (pool index 1) with the exact address and size.
- R3: Kind code 2 (uncacheable read) allocates in the miss pool with the exact address and size, not aligned.
- R4: Each accepted allocation takes the lowest free slot of its pool and is stamped with an order number. The order number is 0 after reset and rises by one per accepted allocation only.
- R5: A request to a pool with no free slot, or with kind code 3, gives rsp_err_o one cycle later. It changes no occupancy, mask, counter or order number.
- R6: An accepted allocation that fills its pool sets mask bit 0 (miss pool) or bit 1 (write pool), visible one cycle later.
- R7: Marking a write-pool entry in service frees it. Marking a miss-pool entry in service keeps the slot and only flags it. In either pool, a free that leaves a full pool not full clears only that pool's cause bit.
- R8: blocked_o is high exactly when the mask is non-zero. A zero to non-zero step adds one to the event counter of the lowest newly set cause. Setting a further cause while already blocked changes no event counter.
- R9: When the mask returns to zero, the number of cycles blocked_o was high is added to the cycle counter of the lowest cause cleared in that final step.
- R10: An accepted allocation with alloc_bus_i high pulses bus_req_o for one cycle, with bus_cause_o equal to the pool index. A rejected one gives no pulse.
- R11: With MISS_LIMIT non-zero, miss_done_o rises once MISS_LIMIT miss-pool allocations have been accepted, and it stays high.
- R12: Mask bit 2 follows tgt_full_i with one cycle of delay.
- R13: The lookup port shows valid, in-service, address, size and order of the selected slot of the selected pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_kind_i | input | 2 | 0 miss, 1 write, 2 uncacheable read, 3 reserved |
| alloc_addr_i | input | AW | Request address |
| alloc_size_i | input | SW | Request size in bytes |
| alloc_bus_i | input | 1 | Request asks for the memory-side bus |
| svc_valid_i | input | 1 | Mark an entry in service |
| svc_pool_i | input | 1 | Pool of the in-service mark |
| svc_slot_i | input | SLW | Slot of the in-service mark |
| rel_valid_i | input | 1 | Release an entry |
| rel_pool_i | input | 1 | Pool of the release |
| rel_slot_i | input | SLW | Slot of the release |
| tgt_full_i | input | 1 | No free target slots |
| look_pool_i | input | 1 | Lookup pool |
| look_slot_i | input | SLW | Lookup slot |
| look_valid_o | output | 1 | Looked-up slot is allocated |
| look_insvc_o | output | 1 | Looked-up slot is in service |
| look_addr_o | output | AW | Stored address |
| look_size_o | output | SW | Stored size |
| look_order_o | output | OW | Stored order number |
| rsp_ok_o | output | 1 | Previous request accepted |
| rsp_err_o | output | 1 | Previous request rejected |
| rsp_pool_o | output | 1 | Pool of accepted request |
| rsp_slot_o | output | SLW | Slot of accepted request |
| rsp_addr_o | output | AW | Stored address |
| rsp_size_o | output | SW | Stored size |
| rsp_order_o | output | OW | Order number given |
| bus_req_o | output | 1 | Memory-side bus request pulse |
| bus_cause_o | output | 2 | Pool index behind the bus request |
| blocked_o | output | 1 | CPU-side blocked |
| blk_mask_o | output | 3 | Cause mask: bit 0 miss pool, bit 1 write pool, bit 2 targets |
| blk_events_o | output | 3*CW | Per-cause blocking event counters, cause c at [c*CW +: CW] |
| blk_cycles_o | output | 3*CW | Per-cause blocked cycle counters, same packing |
| miss_done_o | output | 1 | Miss limit reached |

## Verification
A wrong occupancy count shows at the ports in one of two ways: a false rsp_err_o, or a cause bit that is set or cleared at the wrong moment. Either appears one cycle after the allocation or free that exposes it. A stale slot-valid bit shows as a wrong rsp_slot_o or a wrong lookup result on the next allocation into that pool. A wrong blocking timestamp stays hidden until the episode ends. It then shows as a cycle counter that differs from the number of cycles blocked_o was seen high. A mis-chosen event cause shows in the event counters on the first cycle of blocking.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    KIND_MISS     = 2'd0,
    KIND_WRITE    = 2'd1,
    KIND_UNC_READ = 2'd2,
    KIND_RSVD     = 2'd3
  } alloc_kind_e;

  localparam int unsigned NUM_CAUSES = 3;
  localparam int unsigned CAUSE_MISS = 0;
  localparam int unsigned CAUSE_WB   = 1;
  localparam int unsigned CAUSE_TGT  = 2;
endpackage

// File: rtl/mac_pool.sv
module mac_pool #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 32,
  parameter int unsigned SW    = 8,
  parameter int unsigned OW    = 16,
  parameter int unsigned SLW   = 2,
  parameter bit          FREE_ON_SVC = 1'b0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           alloc_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [SW-1:0]  size_i,
  input  logic [OW-1:0]  order_i,
  output logic           accept_o,
  output logic [SLW-1:0] slot_o,
  input  logic           svc_i,
  input  logic [SLW-1:0] svc_slot_i,
  input  logic           rel_i,
  input  logic [SLW-1:0] rel_slot_i,
  input  logic [SLW-1:0] look_slot_i,
  output logic           look_valid_o,
  output logic           look_insvc_o,
  output logic [AW-1:0]  look_addr_o,
  output logic [SW-1:0]  look_size_o,
  output logic [OW-1:0]  look_order_o,
  output logic           full_o,
  output logic           set_o,
  output logic           clr_o
);
  localparam int unsigned CNTW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] valid_q, insvc_q, rel_vec, svc_vec, free_vec;
  logic [AW-1:0]    addr_q  [DEPTH];
  logic [SW-1:0]    size_q  [DEPTH];
  logic [OW-1:0]    order_q [DEPTH];
  logic [CNTW-1:0]  occ_q, occ_d, nfree;
  logic             free_found;
  logic [SLW-1:0]   free_idx;

  // lowest free slot
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        free_found = 1'b1;
        free_idx   = SLW'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rel_vec[i] = rel_i && (rel_slot_i == SLW'(i)) && valid_q[i];
      svc_vec[i] = svc_i && (svc_slot_i == SLW'(i)) && valid_q[i] && !insvc_q[i];
    end
  end

  generate
    if (FREE_ON_SVC) begin : g_svc_frees
      assign free_vec = rel_vec | svc_vec;
    end else begin : g_svc_keeps
      assign free_vec = rel_vec;
    end
  endgenerate

  assign nfree    = CNTW'($countones(free_vec));
  assign accept_o = alloc_i && free_found;
  assign slot_o   = free_idx;
  assign full_o   = (occ_q == CNTW'(DEPTH));
  assign occ_d    = occ_q + CNTW'(accept_o) - nfree;
  assign set_o    = accept_o && (occ_d == CNTW'(DEPTH));
  assign clr_o    = full_o && (occ_d != CNTW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      insvc_q <= '0;
      occ_q   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i]  <= '0;
        size_q[i]  <= '0;
        order_q[i] <= '0;
      end
    end else begin
      occ_q <= occ_d;
      for (int i = 0; i < DEPTH; i++) begin
        if (free_vec[i]) begin
          valid_q[i] <= 1'b0;
          insvc_q[i] <= 1'b0;
        end else if (svc_vec[i]) begin
          insvc_q[i] <= 1'b1;
        end
        if (accept_o && (free_idx == SLW'(i))) begin
          valid_q[i] <= 1'b1;
          insvc_q[i] <= 1'b0;
          addr_q[i]  <= addr_i;
          size_q[i]  <= size_i;
          order_q[i] <= order_i;
        end
      end
    end
  end

  always_comb begin
    look_valid_o = 1'b0;
    look_insvc_o = 1'b0;
    look_addr_o  = '0;
    look_size_o  = '0;
    look_order_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (look_slot_i == SLW'(i)) begin
        look_valid_o = valid_q[i];
        look_insvc_o = insvc_q[i];
        look_addr_o  = addr_q[i];
        look_size_o  = size_q[i];
        look_order_o = order_q[i];
      end
    end
  end

  a_r5_occ_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= CNTW'(DEPTH));

  a_r5_reject_holds_occ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !free_found) |=> (occ_q <= $past(occ_q)));

  a_r7_occ_tracks_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(valid_q) == int'(occ_q));
endmodule

// File: rtl/mac_block_ctrl.sv
module mac_block_ctrl #(
  parameter int unsigned NC = 3,
  parameter int unsigned CW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NC-1:0]  set_i,
  input  logic [NC-1:0]  clr_i,
  output logic [NC-1:0]  mask_o,
  output logic           blocked_o,
  output logic [NC*CW-1:0] events_o,
  output logic [NC*CW-1:0] cycles_o
);
  localparam int unsigned CIW = (NC > 1) ? $clog2(NC) : 1;

  logic [NC-1:0]  mask_q, mask_d;
  logic [CW-1:0]  cyc_q, start_q;
  logic [CW-1:0]  ev_q [NC];
  logic [CW-1:0]  cy_q [NC];
  logic           rise, fall;
  logic [CIW-1:0] rise_c, fall_c;

  function automatic logic [CIW-1:0] lowest_bit(input logic [NC-1:0] v);
    lowest_bit = '0;
    for (int i = NC - 1; i >= 0; i--) begin
      if (v[i]) lowest_bit = CIW'(i);
    end
  endfunction

  assign mask_d = (mask_q | set_i) & ~clr_i;
  assign rise   = (mask_q == '0) && (mask_d != '0);
  assign fall   = (mask_q != '0) && (mask_d == '0);
  assign rise_c = lowest_bit(mask_d);
  assign fall_c = lowest_bit(mask_q & clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      cyc_q   <= '0;
      start_q <= '0;
      for (int i = 0; i < NC; i++) begin
        ev_q[i] <= '0;
        cy_q[i] <= '0;
      end
    end else begin
      mask_q <= mask_d;
      cyc_q  <= cyc_q + CW'(1);
      if (rise) start_q <= cyc_q;
      for (int i = 0; i < NC; i++) begin
        if (rise && (rise_c == CIW'(i))) ev_q[i] <= ev_q[i] + CW'(1);
        if (fall && (fall_c == CIW'(i))) cy_q[i] <= cy_q[i] + (cyc_q - start_q);
      end
    end
  end

  generate
    for (genvar g = 0; g < NC; g++) begin : g_pack
      assign events_o[g*CW +: CW] = ev_q[g];
      assign cycles_o[g*CW +: CW] = cy_q[g];
    end
  endgenerate

  assign mask_o    = mask_q;
  assign blocked_o = |mask_q;

  a_r8_events_hold_while_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q != '0) |=> $stable(events_o));

  a_r9_cycles_hold_mid_episode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mask_q != '0) && (mask_d != '0)) |=> $stable(cycles_o));

  a_r8_rise_gives_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mask_q == '0) && (set_i & ~clr_i) != '0) |=> blocked_o);
endmodule

// File: rtl/mac_miss_limit.sv
module mac_miss_limit #(
  parameter int unsigned LIMIT = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic count_i,
  output logic done_o
);
  generate
    if (LIMIT == 0) begin : g_off
      assign done_o = 1'b0;
    end else begin : g_on
      localparam int unsigned LW = $clog2(LIMIT + 1);
      logic [LW-1:0] left_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) left_q <= LW'(LIMIT);
        else if (count_i && (left_q != '0)) left_q <= left_q - LW'(1);
      end
      assign done_o = (left_q == '0);
    end
  endgenerate

  a_r11_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
endmodule

// File: rtl/mac_alloc_ctrl.sv
module mac_alloc_ctrl
  import mac_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned SW         = 8,
  parameter int unsigned OW         = 16,
  parameter int unsigned CW         = 16,
  parameter int unsigned BLK_BYTES  = 64,
  parameter int unsigned MISS_DEPTH = 4,
  parameter int unsigned WB_DEPTH   = 4,
  parameter int unsigned MISS_LIMIT = 0,
  localparam int unsigned MAXD = (MISS_DEPTH > WB_DEPTH) ? MISS_DEPTH : WB_DEPTH,
  localparam int unsigned SLW  = (MAXD > 1) ? $clog2(MAXD) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               alloc_valid_i,
  input  logic [1:0]         alloc_kind_i,
  input  logic [AW-1:0]      alloc_addr_i,
  input  logic [SW-1:0]      alloc_size_i,
  input  logic               alloc_bus_i,
  input  logic               svc_valid_i,
  input  logic               svc_pool_i,
  input  logic [SLW-1:0]     svc_slot_i,
  input  logic               rel_valid_i,
  input  logic               rel_pool_i,
  input  logic [SLW-1:0]     rel_slot_i,
  input  logic               tgt_full_i,
  input  logic               look_pool_i,
  input  logic [SLW-1:0]     look_slot_i,
  output logic               look_valid_o,
  output logic               look_insvc_o,
  output logic [AW-1:0]      look_addr_o,
  output logic [SW-1:0]      look_size_o,
  output logic [OW-1:0]      look_order_o,
  output logic               rsp_ok_o,
  output logic               rsp_err_o,
  output logic               rsp_pool_o,
  output logic [SLW-1:0]     rsp_slot_o,
  output logic [AW-1:0]      rsp_addr_o,
  output logic [SW-1:0]      rsp_size_o,
  output logic [OW-1:0]      rsp_order_o,
  output logic               bus_req_o,
  output logic [1:0]         bus_cause_o,
  output logic               blocked_o,
  output logic [2:0]         blk_mask_o,
  output logic [3*CW-1:0]    blk_events_o,
  output logic [3*CW-1:0]    blk_cycles_o,
  output logic               miss_done_o
);
  alloc_kind_e kind;
  logic is_miss, is_unc, is_wr;
  logic [AW-1:0] eff_addr;
  logic [SW-1:0] eff_size;
  logic m_acc, w_acc, accepted;
  logic [SLW-1:0] m_slot, w_slot;
  logic m_full, w_full, m_set, w_set, m_clr, w_clr;
  logic m_lv, w_lv, m_li, w_li;
  logic [AW-1:0] m_la, w_la;
  logic [SW-1:0] m_ls, w_ls;
  logic [OW-1:0] m_lo, w_lo;
  logic [OW-1:0] order_q;
  logic [NUM_CAUSES-1:0] set_vec, clr_vec;

  assign kind    = alloc_kind_e'(alloc_kind_i);
  assign is_miss = alloc_valid_i && (kind == KIND_MISS);
  assign is_unc  = alloc_valid_i && (kind == KIND_UNC_READ);
  assign is_wr   = alloc_valid_i && (kind == KIND_WRITE);

  // cacheable misses are block aligned and block sized
  assign eff_addr = is_miss ? (alloc_addr_i & ~AW'(BLK_BYTES - 1)) : alloc_addr_i;
  assign eff_size = is_miss ? SW'(BLK_BYTES) : alloc_size_i;

  mac_pool #(.DEPTH(MISS_DEPTH), .AW(AW), .SW(SW), .OW(OW), .SLW(SLW), .FREE_ON_SVC(1'b0))
  u_miss_pool (
    .clk_i, .rst_ni,
    .alloc_i      (is_miss || is_unc),
    .addr_i       (eff_addr),
    .size_i       (eff_size),
    .order_i      (order_q),
    .accept_o     (m_acc),
    .slot_o       (m_slot),
    .svc_i        (svc_valid_i && !svc_pool_i),
    .svc_slot_i   (svc_slot_i),
    .rel_i        (rel_valid_i && !rel_pool_i),
    .rel_slot_i   (rel_slot_i),
    .look_slot_i  (look_slot_i),
    .look_valid_o (m_lv),
    .look_insvc_o (m_li),
    .look_addr_o  (m_la),
    .look_size_o  (m_ls),
    .look_order_o (m_lo),
    .full_o       (m_full),
    .set_o        (m_set),
    .clr_o        (m_clr)
  );

  mac_pool #(.DEPTH(WB_DEPTH), .AW(AW), .SW(SW), .OW(OW), .SLW(SLW), .FREE_ON_SVC(1'b1))
  u_wb_pool (
    .clk_i, .rst_ni,
    .alloc_i      (is_wr),
    .addr_i       (eff_addr),
    .size_i       (eff_size),
    .order_i      (order_q),
    .accept_o     (w_acc),
    .slot_o       (w_slot),
    .svc_i        (svc_valid_i && svc_pool_i),
    .svc_slot_i   (svc_slot_i),
    .rel_i        (rel_valid_i && rel_pool_i),
    .rel_slot_i   (rel_slot_i),
    .look_slot_i  (look_slot_i),
    .look_valid_o (w_lv),
    .look_insvc_o (w_li),
    .look_addr_o  (w_la),
    .look_size_o  (w_ls),
    .look_order_o (w_lo),
    .full_o       (w_full),
    .set_o        (w_set),
    .clr_o        (w_clr)
  );

  assign accepted = m_acc || w_acc;

  assign set_vec = {tgt_full_i, w_set, m_set};
  assign clr_vec = {!tgt_full_i, w_clr, m_clr};

  mac_block_ctrl #(.NC(NUM_CAUSES), .CW(CW)) u_block (
    .clk_i, .rst_ni,
    .set_i     (set_vec),
    .clr_i     (clr_vec),
    .mask_o    (blk_mask_o),
    .blocked_o (blocked_o),
    .events_o  (blk_events_o),
    .cycles_o  (blk_cycles_o)
  );

  mac_miss_limit #(.LIMIT(MISS_LIMIT)) u_limit (
    .clk_i, .rst_ni,
    .count_i (m_acc),
    .done_o  (miss_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      order_q     <= '0;
      rsp_ok_o    <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_pool_o  <= 1'b0;
      rsp_slot_o  <= '0;
      rsp_addr_o  <= '0;
      rsp_size_o  <= '0;
      rsp_order_o <= '0;
      bus_req_o   <= 1'b0;
      bus_cause_o <= '0;
    end else begin
      rsp_ok_o  <= accepted;
      rsp_err_o <= alloc_valid_i && !accepted;
      bus_req_o <= accepted && alloc_bus_i;
      if (accepted) begin
        order_q     <= order_q + OW'(1);
        rsp_pool_o  <= w_acc;
        rsp_slot_o  <= w_acc ? w_slot : m_slot;
        rsp_addr_o  <= eff_addr;
        rsp_size_o  <= eff_size;
        rsp_order_o <= order_q;
        bus_cause_o <= {1'b0, w_acc};
      end
    end
  end

  assign look_valid_o = look_pool_i ? w_lv : m_lv;
  assign look_insvc_o = look_pool_i ? w_li : m_li;
  assign look_addr_o  = look_pool_i ? w_la : m_la;
  assign look_size_o  = look_pool_i ? w_ls : m_ls;
  assign look_order_o = look_pool_i ? w_lo : m_lo;

  a_r5_ok_err_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_ok_o && rsp_err_o));

  a_r10_bus_needs_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> rsp_ok_o);

  a_r5_full_write_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_wr && w_full) |=> rsp_err_o);

  a_r12_tgt_sets_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_full_i |=> blk_mask_o[2]);
endmodule

// File: tb/mac_alloc_ctrl_test.sv
module mac_alloc_ctrl_test;
  localparam int SLW = 2;

  typedef struct {
    logic        err;
    logic        pool;
    logic [1:0]  slot;
    logic [31:0] addr;
    logic [7:0]  size;
    logic [15:0] order;
    logic        bus;
    string       req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, alloc_bus = 0;
  logic [1:0] alloc_kind = 0;
  logic [31:0] alloc_addr = 0;
  logic [7:0] alloc_size = 0;
  logic svc_valid = 0, svc_pool = 0, rel_valid = 0, rel_pool = 0, tgt_full = 0, look_pool = 0;
  logic [SLW-1:0] svc_slot = 0, rel_slot = 0, look_slot = 0;
  logic look_valid, look_insvc, rsp_ok, rsp_err, rsp_pool, bus_req, blocked, miss_done;
  logic [31:0] look_addr, rsp_addr;
  logic [7:0] look_size, rsp_size;
  logic [15:0] look_order, rsp_order;
  logic [SLW-1:0] rsp_slot;
  logic [1:0] bus_cause;
  logic [2:0] blk_mask;
  logic [47:0] blk_events, blk_cycles;

  int n_tests = 0, n_fail = 0, hi_cnt = 0;
  exp_t sbq[$];
  bit mv [4], wv [4];
  logic [15:0] exp_order = 0;
  int exp_cyc [3] = '{0, 0, 0};

  always #5 clk = ~clk;

  mac_alloc_ctrl #(.MISS_LIMIT(6)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_kind_i(alloc_kind), .alloc_addr_i(alloc_addr),
    .alloc_size_i(alloc_size), .alloc_bus_i(alloc_bus),
    .svc_valid_i(svc_valid), .svc_pool_i(svc_pool), .svc_slot_i(svc_slot),
    .rel_valid_i(rel_valid), .rel_pool_i(rel_pool), .rel_slot_i(rel_slot),
    .tgt_full_i(tgt_full), .look_pool_i(look_pool), .look_slot_i(look_slot),
    .look_valid_o(look_valid), .look_insvc_o(look_insvc), .look_addr_o(look_addr),
    .look_size_o(look_size), .look_order_o(look_order),
    .rsp_ok_o(rsp_ok), .rsp_err_o(rsp_err), .rsp_pool_o(rsp_pool), .rsp_slot_o(rsp_slot),
    .rsp_addr_o(rsp_addr), .rsp_size_o(rsp_size), .rsp_order_o(rsp_order),
    .bus_req_o(bus_req), .bus_cause_o(bus_cause), .blocked_o(blocked),
    .blk_mask_o(blk_mask), .blk_events_o(blk_events), .blk_cycles_o(blk_cycles),
    .miss_done_o(miss_done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ev(input int c);
    return blk_events[c*16 +: 16];
  endfunction
  function automatic logic [15:0] cy(input int c);
    return blk_cycles[c*16 +: 16];
  endfunction

  always @(posedge clk) if (blocked) hi_cnt++;

  // monitor: compare responses against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && (rsp_ok || rsp_err)) begin
      if (sbq.size() == 0) begin
        chk("R4 unexpected response", 64'(rsp_ok), 64'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk({e.req, " err"}, 64'(rsp_err), 64'(e.err));
        chk({e.req, " ok"}, 64'(rsp_ok), 64'(!e.err));
        if (!e.err) begin
          chk({e.req, " pool"}, 64'(rsp_pool), 64'(e.pool));
          chk({e.req, " slot"}, 64'(rsp_slot), 64'(e.slot));
          chk({e.req, " addr"}, 64'(rsp_addr), 64'(e.addr));
          chk({e.req, " size"}, 64'(rsp_size), 64'(e.size));
          chk({e.req, " R4 order"}, 64'(rsp_order), 64'(e.order));
        end
        chk("R10 bus_req", 64'(bus_req), 64'(e.bus));
        if (e.bus) chk("R10 bus_cause", 64'(bus_cause), 64'(e.pool));
      end
    end else if (rst_n && bus_req) begin
      chk("R10 stray bus_req", 64'(bus_req), 64'd0);
    end
  end

  task automatic alloc(input logic [1:0] k, input logic [31:0] a, input logic [7:0] s,
                       input bit bus, input string req);
    exp_t e;
    int fs;
    e.req = req; e.pool = (k == 2'd1); e.err = 1'b1; e.slot = 0; e.order = 0;
    e.addr = (k == 2'd0) ? (a & ~32'h3F) : a;
    e.size = (k == 2'd0) ? 8'd64 : s;
    fs = -1;
    for (int i = 3; i >= 0; i--) if (!(e.pool ? wv[i] : mv[i])) fs = i;
    if (k != 2'd3 && fs >= 0) begin
      e.err = 1'b0; e.slot = 2'(fs); e.order = exp_order; exp_order++;
      if (e.pool) wv[fs] = 1'b1; else mv[fs] = 1'b1;
    end
    e.bus = bus && !e.err;
    sbq.push_back(e);
    alloc_valid = 1; alloc_kind = k; alloc_addr = a; alloc_size = s; alloc_bus = bus;
    @(negedge clk);
    alloc_valid = 0; alloc_bus = 0;
  endtask

  task automatic mark_svc(input bit p, input logic [1:0] sl);
    svc_valid = 1; svc_pool = p; svc_slot = sl;
    @(negedge clk);
    svc_valid = 0;
    if (p) wv[sl] = 1'b0;
  endtask

  task automatic release_slot(input bit p, input logic [1:0] sl);
    rel_valid = 1; rel_pool = p; rel_slot = sl;
    @(negedge clk);
    rel_valid = 0;
    if (p) wv[sl] = 1'b0; else mv[sl] = 1'b0;
  endtask

  bit wd_hit = 0;
  initial begin
    repeat (20000) @(posedge clk);
    wd_hit = 1;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R8 reset blocked", 64'(blocked), 0);
    chk("R8 reset mask", 64'(blk_mask), 0);
    chk("R8 reset events", 64'(blk_events), 0);
    chk("R9 reset cycles", 64'(blk_cycles), 0);
    chk("R11 reset done", 64'(miss_done), 0);

    h0 = hi_cnt;
    alloc(2'd0, 32'h1234, 8'd7, 1, "R1 miss align");
    alloc(2'd0, 32'h5FFF, 8'd1, 0, "R1 miss align high");
    alloc(2'd2, 32'h7003, 8'd4, 1, "R3 uncached read");
    chk("R6 not yet blocked", 64'(blocked), 0);
    alloc(2'd0, 32'h0040, 8'd0, 0, "R1 miss fills pool");
    chk("R6 miss bit set", 64'(blk_mask), 64'b001);
    chk("R8 blocked high", 64'(blocked), 1);
    chk("R8 event cause0", 64'(ev(0)), 1);
    alloc(2'd0, 32'h9000, 8'd0, 1, "R5 full pool reject");
    chk("R5 mask unchanged", 64'(blk_mask), 64'b001);
    chk("R5 events unchanged", 64'(ev(0)), 1);

    alloc(2'd1, 32'h1001, 8'd3, 1, "R2 write exact");
    alloc(2'd1, 32'h2002, 8'd5, 0, "R2 write");
    alloc(2'd1, 32'h3003, 8'd8, 0, "R2 write");
    alloc(2'd1, 32'h4004, 8'd2, 0, "R2 write fills pool");
    chk("R6 write bit set", 64'(blk_mask), 64'b011);
    chk("R8 no second event", 64'(ev(1)), 0);
    chk("R8 cause0 events still", 64'(ev(0)), 1);
    alloc(2'd3, 32'h0, 8'd0, 0, "R5 reserved kind");

    mark_svc(1'b0, 2'd1);
    chk("R7 miss svc keeps bit", 64'(blk_mask), 64'b011);
    look_pool = 0; look_slot = 2'd1; #1;
    chk("R13 look valid", 64'(look_valid), 1);
    chk("R13 look insvc", 64'(look_insvc), 1);
    chk("R13 look addr", 64'(look_addr), 64'h5FC0);
    chk("R13 look size", 64'(look_size), 64);
    chk("R13 look order", 64'(look_order), 1);
    look_pool = 1; look_slot = 2'd0; #1;
    chk("R13 look write addr", 64'(look_addr), 64'h1001);
    chk("R13 look write order", 64'(look_order), 4);
    @(negedge clk);
    alloc(2'd0, 32'h1111, 8'd0, 0, "R7 in-service miss slot still held");

    mark_svc(1'b1, 2'd2);
    chk("R7 write svc clears bit1", 64'(blk_mask), 64'b001);
    look_pool = 1; look_slot = 2'd2; #1;
    chk("R7 write entry freed", 64'(look_valid), 0);
    @(negedge clk);

    tgt_full = 1;
    @(negedge clk);
    chk("R12 tgt bit set", 64'(blk_mask), 64'b101);
    chk("R8 no event for tgt", 64'(ev(2)), 0);
    tgt_full = 0;
    @(negedge clk);
    chk("R12 tgt bit clear", 64'(blk_mask), 64'b001);

    release_slot(1'b0, 2'd1);
    chk("R7 release clears", 64'(blk_mask), 0);
    chk("R8 unblocked", 64'(blocked), 0);
    exp_cyc[0] += hi_cnt - h0;
    chk("R9 cycles cause0", 64'(cy(0)), 64'(exp_cyc[0]));
    chk("R9 cycles cause1", 64'(cy(1)), 0);
    chk("R9 cycles cause2", 64'(cy(2)), 0);

    // target-only episode
    h0 = hi_cnt;
    tgt_full = 1;
    repeat (3) @(negedge clk);
    tgt_full = 0;
    @(negedge clk);
    chk("R12 tgt episode ended", 64'(blocked), 0);
    chk("R8 tgt event", 64'(ev(2)), 1);
    exp_cyc[2] += hi_cnt - h0;
    chk("R9 tgt cycles", 64'(cy(2)), 64'(exp_cyc[2]));
    chk("R9 tgt cycles length", 64'(cy(2)), 3);

    // miss limit
    h0 = hi_cnt;
    alloc(2'd0, 32'h9999, 8'd0, 0, "R4 reuse lowest free slot");
    chk("R11 not done at five", 64'(miss_done), 0);
    chk("R8 second cause0 event", 64'(ev(0)), 2);
    release_slot(1'b0, 2'd0);
    exp_cyc[0] += hi_cnt - h0;
    chk("R9 cycles accumulate", 64'(cy(0)), 64'(exp_cyc[0]));
    alloc(2'd2, 32'h0ABC, 8'd2, 1, "R3 uncached read slot0");
    chk("R11 done at six", 64'(miss_done), 1);
    chk("R8 third cause0 event", 64'(ev(0)), 3);
    repeat (2) @(negedge clk);
    chk("R11 done sticky", 64'(miss_done), 1);
    chk("R4 scoreboard drained", 64'(sbq.size()), 0);

    if (!wd_hit) begin
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule